// File: doc/BRIEF.md
# Converter Mode and Channel Sequencer

This block controls a capacitance converter that has one modulator and one excitation source shared by two sensor channels. A host writes a 3-bit operating mode, two channel-enable bits and a 2-bit oversampling selection. The sequencer then runs conversion or calibration cycles on the enabled channels. During each cycle it points the input multiplexer and the excitation driver at the active channel. It times every cycle from the oversampling selection and signals the end of the cycle with a strobe that tells the datapath what to do with the filter output: capture a result, update the offset coefficient or update the gain coefficient.

Single conversions and both calibrations visit each enabled channel once, channel 1 first. When they finish, the stored mode goes back to idle and a done flag is raised. Continuous conversion keeps going until a new mode is written. If both channels are enabled it alternates between them. A mode write in the middle of a cycle abandons that cycle and the sequencer restarts under the new mode. The modulator and the filter are represented only by a cycle timer, which is scaled by a clock-cycles-per-millisecond parameter.

Top module: `cdc_seq_ctrl`

## Requirements
- R1: After reset, mode_rb reads 000 and busy, exc_drv, data_rdy, done, mode_err and all strobes are 0.
- R2: Mode 000 starts no activity. Codes 100 and 111 also start no activity, but they set mode_err while they are stored. Every other code clears mode_err.
- R3: Mode 011 (power-down) sets pwr_dn and keeps busy and exc_drv at 0. After a later write, the new mode runs normally starting from idle.
- R4: One cycle lasts L = T x CLK_PER_MS clocks, where T is 5, 20, 50 or 60 ms for osr_sel 00, 01, 10 or 11. The first strobe appears L+1 clocks after the edge that accepts cfg_wr.
- R5: Mode 010 (single) converts each enabled channel once, channel 1 before channel 2. On the edge of its last strobe, mode_rb becomes 000 and done becomes 1. If no channel is enabled, this completion happens on the next edge.
- R6: Mode 001 (continuous) repeats without end and mode_rb stays 001. With cfg_chen = 11 the channels alternate 1, 2, 1, 2. With a single channel enabled, that channel repeats.
- R7: Modes 101 and 110 (offset and gain calibration) pulse off_upd or gain_upd respectively, once per enabled channel. They never pulse cap_stb, never set data_rdy, and complete like R5.
- R8: While busy, mux_sel gives the active channel (0 = channel 1, 1 = channel 2) and exc_drv is one-hot (bit 0 = channel 1 excitation, bit 1 = channel 2 excitation). When not busy, exc_drv is 00.
- R9: A cfg_wr accepted while busy ends the current cycle with no strobe. Under the new mode the sequencer starts from the first enabled channel and runs a full cycle.
- R10: data_rdy[c] is set with each cap_stb where res_ch = c. It is cleared by rd_ack[c]. If both happen on the same edge, the set wins.
- R11: Every accepted cfg_wr clears done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | One-cycle pulse that loads cfg_mode and cfg_chen |
| cfg_mode | input | 3 | Operating mode code |
| cfg_chen | input | 2 | Channel enables, bit 0 = channel 1 |
| osr_sel | input | 2 | Oversampling / conversion-time selection |
| rd_ack | input | 2 | Host has read the result of channel c |
| mode_rb | output | 3 | Stored mode, returns to 000 on completion |
| mode_err | output | 1 | Stored mode code is invalid |
| pwr_dn | output | 1 | Power-down mode is active |
| busy | output | 1 | A conversion or calibration cycle is running |
| mux_sel | output | 1 | Input multiplexer channel select |
| exc_drv | output | 2 | One-hot excitation driver enable |
| cap_stb | output | 1 | Capture the filter result now |
| off_upd | output | 1 | Write the offset coefficient now |
| gain_upd | output | 1 | Write the gain coefficient now |
| res_ch | output | 1 | Channel of the current strobe |
| data_rdy | output | 2 | Per-channel result-ready flags |
| done | output | 1 | Single conversion or calibration has completed |

## Verification
The hardest case to create is an abort: a mode write has to land in the middle of a running cycle, when the timer has advanced partway but has not expired. The bench issues a single conversion with a long oversampling setting, waits half a cycle, and then writes a new single-channel mode. The scoreboard then holds exactly one expected capture, timed a full cycle after the second write. Any strobe left over from the abandoned cycle, or a restart that comes too early, shows up as a mismatch. Alternation in continuous mode and immediate completion with no channels enabled are reached in the same way: every expected event is queued with its exact clock cycle.

// File: rtl/cdc_seq_pkg.sv
// Package: shared types and the conversion-time table for the sequencer.
// Assumes: the caller multiplies the millisecond value by its own clock rate.
package cdc_seq_pkg;

    typedef enum logic [2:0] {
        MD_IDLE    = 3'd0,
        MD_CONT    = 3'd1,
        MD_SINGLE  = 3'd2,
        MD_PDOWN   = 3'd3,
        MD_BAD_A   = 3'd4,
        MD_OFFCAL  = 3'd5,
        MD_GAINCAL = 3'd6,
        MD_BAD_B   = 3'd7
    } mode_e;

    typedef enum logic [1:0] {
        OP_NONE    = 2'd0,
        OP_CONV    = 2'd1,
        OP_OFFCAL  = 2'd2,
        OP_GAINCAL = 2'd3
    } op_e;

    localparam int unsigned MAX_MS = 60;

    // Conversion time in milliseconds for an oversampling code
    function automatic int unsigned osr_ms(input logic [1:0] code);
        case (code)
            2'd0:    return 5;
            2'd1:    return 20;
            2'd2:    return 50;
            default: return MAX_MS;
        endcase
    endfunction

endpackage

// File: rtl/cdc_mode_dec.sv
// Module: decodes the stored mode code into the kind of cycle to run.
// Assumes: the code is held in a register by the caller; purely combinational.
module cdc_mode_dec
    import cdc_seq_pkg::*;
(
    input  logic [2:0] mode,
    output op_e        op,
    output logic       repeat_run,
    output logic       pd,
    output logic       err
);

    // Map each code to its operation; invalid codes act as idle
    always_comb begin
        op         = OP_NONE;
        repeat_run = 1'b0;
        pd         = 1'b0;
        err        = 1'b0;
        case (mode_e'(mode))
            MD_CONT:    begin op = OP_CONV; repeat_run = 1'b1; end
            MD_SINGLE:  op = OP_CONV;
            MD_OFFCAL:  op = OP_OFFCAL;
            MD_GAINCAL: op = OP_GAINCAL;
            MD_PDOWN:   pd = 1'b1;
            MD_BAD_A,
            MD_BAD_B:   err = 1'b1;
            default:    op = OP_NONE;
        endcase
    end

endmodule

// File: rtl/cdc_conv_timer.sv
// Module: stands in for the modulator and filter by counting one conversion time.
// Assumes: clr wins over run; tick is raised in the last clock of a cycle.
module cdc_conv_timer
    import cdc_seq_pkg::*;
#(
    parameter int unsigned CLK_PER_MS = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       run,
    input  logic [1:0] osr,
    output logic       tick
);

    localparam int unsigned MAX_CYC = MAX_MS * CLK_PER_MS;
    localparam int unsigned CW      = $clog2(MAX_CYC + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    // Cycle length for the selected oversampling code
    always_comb lim = CW'(osr_ms(osr) * CLK_PER_MS);

    // Last clock of the running cycle
    always_comb tick = run && (cnt == lim - CW'(1));

    // Elapsed-clock counter, gated when not running
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (run)      cnt <= cnt + CW'(1);
    end

endmodule

// File: rtl/cdc_chan_pick.sv
// Module: chooses the first, following and alternating channel from the enables.
// Assumes: channel 0 is the first channel; combinational only.
module cdc_chan_pick (
    input  logic [1:0] chen,
    input  logic       cur,
    output logic       first_ch,
    output logic       has_next,
    output logic       alt_ch
);

    // First enabled channel, in ascending order
    always_comb first_ch = chen[0] ? 1'b0 : 1'b1;

    // A one-pass run still has channel 1 to visit
    always_comb has_next = (cur == 1'b0) && chen[1];

    // Continuous mode: switch to the other channel if it is enabled
    always_comb alt_ch = chen[~cur] ? ~cur : cur;

endmodule

// File: rtl/cdc_seq_ctrl.sv
// Module: converter mode and channel sequencer (top).
// Holds the mode and enable register, sequences cycles over the enabled
// channels, steers the multiplexer and excitation, and issues result strobes.
// Assumes: cfg_wr is a one-clock pulse; osr_sel stays stable during a cycle.
module cdc_seq_ctrl
    import cdc_seq_pkg::*;
#(
    parameter int unsigned CLK_PER_MS = 1000,
    parameter int unsigned NCH        = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_wr,
    input  logic [2:0]     cfg_mode,
    input  logic [NCH-1:0] cfg_chen,
    input  logic [1:0]     osr_sel,
    input  logic [NCH-1:0] rd_ack,
    output logic [2:0]     mode_rb,
    output logic           mode_err,
    output logic           pwr_dn,
    output logic           busy,
    output logic           mux_sel,
    output logic [NCH-1:0] exc_drv,
    output logic           cap_stb,
    output logic           off_upd,
    output logic           gain_upd,
    output logic           res_ch,
    output logic [NCH-1:0] data_rdy,
    output logic           done
);

    logic [2:0]     mode_q;
    logic [NCH-1:0] chen_q;
    logic           act_ch;
    op_e            op;
    logic           repeat_run;
    logic           tick;
    logic           first_ch;
    logic           has_next;
    logic           alt_ch;

    cdc_mode_dec u_dec (
        .mode       (mode_q),
        .op         (op),
        .repeat_run (repeat_run),
        .pd         (pwr_dn),
        .err        (mode_err)
    );

    cdc_conv_timer #(.CLK_PER_MS(CLK_PER_MS)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!busy || tick || cfg_wr),
        .run   (busy),
        .osr   (osr_sel),
        .tick  (tick)
    );

    cdc_chan_pick u_pick (
        .chen     (chen_q),
        .cur      (act_ch),
        .first_ch (first_ch),
        .has_next (has_next),
        .alt_ch   (alt_ch)
    );

    // Output steering for the shared input multiplexer and excitation
    always_comb begin
        mode_rb = mode_q;
        mux_sel = act_ch;
        exc_drv = '0;
        if (busy) exc_drv[act_ch] = 1'b1;
    end

    // Mode register, cycle sequencing, strobes and ready flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MD_IDLE;
            chen_q   <= '0;
            busy     <= 1'b0;
            act_ch   <= 1'b0;
            done     <= 1'b0;
            cap_stb  <= 1'b0;
            off_upd  <= 1'b0;
            gain_upd <= 1'b0;
            res_ch   <= 1'b0;
            data_rdy <= '0;
        end else begin
            cap_stb  <= 1'b0;
            off_upd  <= 1'b0;
            gain_upd <= 1'b0;
            data_rdy <= data_rdy & ~rd_ack;
            if (cfg_wr) begin
                mode_q <= cfg_mode;
                chen_q <= cfg_chen;
                busy   <= 1'b0;
                done   <= 1'b0;
            end else if (!busy) begin
                if (op != OP_NONE) begin
                    if (chen_q != '0) begin
                        busy   <= 1'b1;
                        act_ch <= first_ch;
                    end else if (!repeat_run) begin
                        mode_q <= MD_IDLE;
                        done   <= 1'b1;
                    end
                end
            end else if (tick) begin
                res_ch <= act_ch;
                case (op)
                    OP_CONV: begin
                        cap_stb          <= 1'b1;
                        data_rdy[act_ch] <= 1'b1;
                    end
                    OP_OFFCAL:  off_upd  <= 1'b1;
                    OP_GAINCAL: gain_upd <= 1'b1;
                    default:    cap_stb  <= 1'b0;
                endcase
                if (repeat_run) begin
                    act_ch <= alt_ch;
                end else if (has_next) begin
                    act_ch <= 1'b1;
                end else begin
                    busy   <= 1'b0;
                    mode_q <= MD_IDLE;
                    done   <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/cdc_seq_ctrl_chk.sv
// Module: assertion checker for the sequencer, attached with bind.
// Assumes: observes only the top-level ports.
module cdc_seq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wr,
    input logic [2:0] mode_rb,
    input logic       mode_err,
    input logic       pwr_dn,
    input logic       busy,
    input logic [1:0] exc_drv,
    input logic       cap_stb,
    input logic       off_upd,
    input logic       gain_upd,
    input logic       res_ch,
    input logic [1:0] data_rdy,
    input logic       done
);

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> !busy);                                     // R2
    AST_PD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |-> (!busy && exc_drv == 2'b00));                 // R3
    AST_STROBE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_stb || off_upd || gain_upd) |-> $past(busy));       // R4
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mode_rb == 3'd0));                             // R5
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cap_stb, off_upd, gain_upd}));                 // R7
    AST_NO_STROBE_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !(cap_stb || off_upd || gain_upd));           // R9
    AST_CAP_SETS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb |-> data_rdy[res_ch]);                           // R10
    AST_WR_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !done);                                       // R11

endmodule

bind cdc_seq_ctrl cdc_seq_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .mode_rb  (mode_rb),
    .mode_err (mode_err),
    .pwr_dn   (pwr_dn),
    .busy     (busy),
    .exc_drv  (exc_drv),
    .cap_stb  (cap_stb),
    .off_upd  (off_upd),
    .gain_upd (gain_upd),
    .res_ch   (res_ch),
    .data_rdy (data_rdy),
    .done     (done)
);

// File: tb/cdc_seq_ctrl_test.sv
// Bench: scoreboard of timed strobe events for the sequencer.
module cdc_seq_ctrl_test;

    localparam int unsigned CPMS = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [2:0] cfg_mode = 3'd0;
    logic [1:0] cfg_chen = 2'd0;
    logic [1:0] osr_sel = 2'd0;
    logic [1:0] rd_ack = 2'd0;
    logic [2:0] mode_rb;
    logic       mode_err, pwr_dn, busy, mux_sel;
    logic [1:0] exc_drv;
    logic       cap_stb, off_upd, gain_upd, res_ch;
    logic [1:0] data_rdy;
    logic       done;

    cdc_seq_ctrl #(.CLK_PER_MS(CPMS)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
        .cfg_chen(cfg_chen), .osr_sel(osr_sel), .rd_ack(rd_ack),
        .mode_rb(mode_rb), .mode_err(mode_err), .pwr_dn(pwr_dn), .busy(busy),
        .mux_sel(mux_sel), .exc_drv(exc_drv), .cap_stb(cap_stb),
        .off_upd(off_upd), .gain_upd(gain_upd), .res_ch(res_ch),
        .data_rdy(data_rdy), .done(done)
    );

    always #5 clk = ~clk;

    typedef struct { int kind; int ch; int cyc; } ev_t;   // kind 1 cap, 2 off, 3 gain
    ev_t sb[$];
    int  cyc = 0;
    int  n_chk = 0;
    int  n_fail = 0;
    int  wcyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Monitor: pop and compare each strobe as it appears
    always @(negedge clk) begin
        if (rst_n && (cap_stb || off_upd || gain_upd)) begin
            int k;
            ev_t e;
            k = cap_stb ? 1 : (off_upd ? 2 : 3);
            if (sb.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R4 unexpected strobe: actual kind %0d ch %0d cycle %0d expected none",
                         k, res_ch, cyc);
            end else begin
                e = sb.pop_front();
                check_eq("R4 event cycle", cyc, e.cyc);
                check_eq("R7 event kind", k, e.kind);
                check_eq("R6 event channel", int'(res_ch), e.ch);
            end
        end
    end

    // Driver: expected item into the scoreboard
    task automatic expect_ev(input int kind, input int ch, input int at);
        ev_t e;
        e.kind = kind; e.ch = ch; e.cyc = at;
        sb.push_back(e);
    endtask

    task automatic wr_cfg(input int md, input int en, input int os);
        @(negedge clk);
        cfg_mode = 3'(md); cfg_chen = 2'(en); osr_sel = 2'(os);
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        wcyc = cyc;
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic pulse_rd(input int m);
        @(negedge clk);
        rd_ack = 2'(m);
        @(negedge clk);
        rd_ack = 2'd0;
    endtask

    task automatic sb_empty(input string req);
        check_eq(req, sb.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_eq("R1 mode_rb", mode_rb, 0);
        check_eq("R1 busy", busy, 0);
        check_eq("R1 exc_drv", exc_drv, 0);
        check_eq("R1 data_rdy", data_rdy, 0);
        check_eq("R1 done", done, 0);
        check_eq("R1 mode_err", mode_err, 0);

        // R5 single, both channels, L=10
        wr_cfg(2, 3, 0); w = wcyc;
        expect_ev(1, 0, w + 11); expect_ev(1, 1, w + 21);
        wait_to(w + 5);
        check_eq("R8 mux ch1", mux_sel, 0);
        check_eq("R8 exc ch1", exc_drv, 1);
        wait_to(w + 15);
        check_eq("R8 mux ch2", mux_sel, 1);
        check_eq("R8 exc ch2", exc_drv, 2);
        wait_to(w + 21);
        check_eq("R10 both ready", data_rdy, 3);
        check_eq("R5 done", done, 1);
        check_eq("R5 mode back idle", mode_rb, 0);
        wait_to(w + 30);
        check_eq("R8 exc off when idle", exc_drv, 0);
        sb_empty("R5 one pass only");
        pulse_rd(1);
        check_eq("R10 read clears ch1", data_rdy, 2);
        pulse_rd(2);
        check_eq("R10 read clears ch2", data_rdy, 0);

        // R6 continuous, channel 2 only, L=40
        wr_cfg(1, 2, 1); w = wcyc;
        check_eq("R11 write clears done", done, 0);
        expect_ev(1, 1, w + 41); expect_ev(1, 1, w + 81); expect_ev(1, 1, w + 121);
        wait_to(w + 100);
        check_eq("R6 mode stays continuous", mode_rb, 1);
        check_eq("R8 exc ch2 only", exc_drv, 2);
        wait_to(w + 130);
        wr_cfg(0, 2, 1); w = wcyc;
        wait_to(w + 50);
        sb_empty("R6 stop after idle");
        check_eq("R2 idle not busy", busy, 0);

        // R6 continuous, both channels, L=10: alternation
        wr_cfg(1, 3, 0); w = wcyc;
        expect_ev(1, 0, w + 11); expect_ev(1, 1, w + 21);
        expect_ev(1, 0, w + 31); expect_ev(1, 1, w + 41);
        wait_to(w + 45);
        wr_cfg(0, 3, 0); w = wcyc;
        wait_to(w + 20);
        sb_empty("R6 alternation");
        pulse_rd(3);

        // R7 offset calibration on channel 1, gain on both
        wr_cfg(5, 1, 0); w = wcyc;
        expect_ev(2, 0, w + 11);
        wait_to(w + 12);
        check_eq("R7 offcal done", done, 1);
        check_eq("R7 offcal idle", mode_rb, 0);
        check_eq("R7 no ready from cal", data_rdy, 0);
        wr_cfg(6, 3, 0); w = wcyc;
        expect_ev(3, 0, w + 11); expect_ev(3, 1, w + 21);
        wait_to(w + 25);
        check_eq("R7 gaincal idle", mode_rb, 0);
        check_eq("R7 no ready from gain", data_rdy, 0);
        sb_empty("R7 cal events");

        // R9 abort mid-cycle, L=100
        wr_cfg(2, 3, 2); w = wcyc;
        wait_to(w + 50);
        wr_cfg(2, 1, 2); w = wcyc;
        expect_ev(1, 0, w + 101);
        wait_to(w + 2);
        check_eq("R9 restarted busy", busy, 1);
        check_eq("R9 restart on ch1", mux_sel, 0);
        check_eq("R9 no ready from aborted", data_rdy, 0);
        wait_to(w + 102);
        check_eq("R9 result after restart", data_rdy, 1);
        sb_empty("R9 only restarted event");
        pulse_rd(1);

        // R2 invalid codes
        wr_cfg(4, 3, 0); w = wcyc;
        check_eq("R2 err on 100", mode_err, 1);
        wait_to(w + 30);
        check_eq("R2 100 not busy", busy, 0);
        check_eq("R2 100 kept", mode_rb, 4);
        wr_cfg(7, 3, 0); w = wcyc;
        check_eq("R2 err on 111", mode_err, 1);
        wait_to(w + 30);
        check_eq("R2 111 not busy", busy, 0);
        wr_cfg(0, 3, 0);
        check_eq("R2 err cleared", mode_err, 0);

        // R3 power-down, then continuous channel 1
        wr_cfg(3, 3, 0); w = wcyc;
        check_eq("R3 pwr_dn", pwr_dn, 1);
        wait_to(w + 30);
        check_eq("R3 not busy", busy, 0);
        check_eq("R3 exc off", exc_drv, 0);
        wr_cfg(1, 1, 0); w = wcyc;
        check_eq("R3 left power-down", pwr_dn, 0);
        expect_ev(1, 0, w + 11); expect_ev(1, 0, w + 21);
        wait_to(w + 25);
        wr_cfg(0, 1, 0);
        pulse_rd(3);

        // R4 longest setting, L=120
        wr_cfg(2, 1, 3); w = wcyc;
        expect_ev(1, 0, w + 121);
        wait_to(w + 120);
        check_eq("R4 still busy before end", busy, 1);
        wait_to(w + 125);
        sb_empty("R4 long cycle");

        // R5 single with no channel enabled
        wr_cfg(2, 0, 0);
        @(negedge clk);
        check_eq("R5 empty run done", done, 1);
        check_eq("R5 empty run idle", mode_rb, 0);
        check_eq("R5 empty run not busy", busy, 0);

        repeat (5) @(negedge clk);
        sb_empty("R4 no stray events");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule